// File: doc/BRIEF.md
# Outstanding Completion Tracking Counter

This block keeps a running count of transfer requests that have been handed to the transfer engines and still owe a completion report. A request adds one to the count when it is admitted and asks for any kind of completion report. Each valid completion code returned by a transfer engine subtracts one. Up to six engines can return codes in the same cycle, and the count drops by exactly the number that arrive. Counting all of them avoids the slow upward creep that an undercounting decrement would cause.

The count is six bits wide and stops at its maximum of 63. At 63 the block refuses new requests by dropping its ready output. It accepts them again as soon as a completion brings the count down. Reaching 63 also sets a sticky error flag. Software clears the flag by writing one to it. When the error interrupt is enabled, the flag drives an interrupt line. The current count is visible on a status output at all times.

Top module: `cpl_track`

## Requirements
- R1: While `rst_ni` is low, the count reads 0, `err_o` and `irq_o` are 0, and `req_rdy_o` is 1.
- R2: A request is admitted when `req_vld_i` and `req_rdy_o` are both high at a rising edge. It adds one to the count only if at least one bit of `req_opt_i` is set: bit 0 final interrupt, bit 1 final chain, bit 2 intermediate interrupt, bit 3 intermediate chain. A request with `req_opt_i` equal to 0, or with `req_vld_i` low, leaves the count unchanged.
- R3: Each bit of `rsp_vld_i` is one engine port. A set bit is one valid completion code. In a cycle, the count falls by the number of set bits, from 0 up to 6.
- R4: When an increment and completions occur in the same cycle, the next count is count + 1 − (number of set bits), applied as one update.
- R5: A completion with no counted request behind it still decrements the count. The count clamps at 0 and never wraps.
- R6: While the count is 63, `req_rdy_o` is 0 and a request is neither admitted nor counted. The count stays at 63 until a completion arrives.
- R7: In the cycle after a completion brings the count below 63, `req_rdy_o` is 1 and requests are counted again.
- R8: `err_o` becomes 1 at the edge where the count becomes 63. It stays 1 after the count drops until software clears it.
- R9: A pulse on `err_clr_i` clears `err_o` at the next edge. If the count becomes 63 at that same edge, the set wins and `err_o` stays 1.
- R10: `irq_o` is `err_o` AND `irq_en_i`.
- R11: `cnt_o` shows the registered count. It changes only at the edge after the inputs that change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | A transfer request is offered |
| req_opt_i | input | 4 | Completion-report options of the offered request |
| req_rdy_o | output | 1 | Request admission allowed (count below 63) |
| rsp_vld_i | input | 6 | One valid completion code per engine port |
| cnt_o | output | 6 | Current outstanding count |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the error flag |
| irq_en_i | input | 1 | Error interrupt enable |
| err_o | output | 1 | Sticky count-saturation error flag |
| irq_o | output | 1 | Error interrupt |

## Verification
The assertions assume that every input is known and synchronous to `clk_i` once reset is released. They also assume that `err_clr_i` is a write strobe and not a level that software holds. The bench changes inputs only on falling edges and drives every input to a known value from time zero. It gives `err_clr_i` single-cycle pulses. It sends completions even when nothing is outstanding, which deliberately exercises the clamp at 0 instead of keeping the stimulus away from it.

// File: rtl/cpl_track_pkg.sv
package cpl_track_pkg;

  localparam int unsigned OPT_W = 4;

  typedef struct packed {
    logic imd_chain;  // bit 3
    logic imd_irq;    // bit 2
    logic fin_chain;  // bit 1
    logic fin_irq;    // bit 0
  } cpl_opt_t;

  function automatic logic wants_report(cpl_opt_t opt);
    return opt.fin_irq | opt.fin_chain | opt.imd_irq | opt.imd_chain;
  endfunction

endpackage

// File: rtl/cpl_rsp_count.sv
module cpl_rsp_count #(
  parameter int unsigned NUM_PORTS = 6,
  localparam int unsigned OUT_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] vld_i,
  output logic [OUT_W-1:0]     num_o
);

  logic [OUT_W-1:0] part [NUM_PORTS+1];

  assign part[0] = '0;

  // running sum across ports, one adder per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sum
    assign part[p+1] = part[p] + OUT_W'(vld_i[p]);
  end

  assign num_o = part[NUM_PORTS];

  assert_zero_ports_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i == '0) |-> (num_o == '0));

  assert_one_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(vld_i) |-> (num_o == OUT_W'(1)));

  assert_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    num_o <= OUT_W'(NUM_PORTS));

endmodule

// File: rtl/cpl_cnt_core.sv
module cpl_cnt_core #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned DEC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [DEC_W-1:0] ndec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o,
  output logic             reach_o
);

  localparam int unsigned SUM_W = ((CNT_W > DEC_W) ? CNT_W : DEC_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] up, net;

  // single net update: +inc -ndec, clamp to [0, max]
  always_comb begin
    up = SUM_W'(cnt_q) + SUM_W'(inc_i);
    if (up < SUM_W'(ndec_i)) net = '0;
    else                     net = up - SUM_W'(ndec_i);
    if (net > SUM_W'(CNT_MAX)) cnt_d = CNT_MAX;
    else                       cnt_d = net[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign sat_o   = (cnt_q == CNT_MAX);
  assign reach_o = (cnt_d == CNT_MAX) && (cnt_q != CNT_MAX);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && ndec_i == '0) |=> $stable(cnt_q));

  assert_single_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ndec_i == '0 && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && SUM_W'(ndec_i) >= SUM_W'(cnt_q)) |=> (cnt_q == '0));

  assert_sat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && ndec_i == '0) |=> (cnt_q == CNT_MAX));

  assert_inc_dec_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ndec_i == DEC_W'(1)) |=> $stable(cnt_q));

endmodule

// File: rtl/cpl_err_ctl.sv
module cpl_err_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic err_o,
  output logic irq_o
);

  logic err_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (set_i) err_q <= 1'b1;
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;
  assign irq_o = err_q & irq_en_i;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o);

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

endmodule

// File: rtl/cpl_track.sv
module cpl_track
  import cpl_track_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned CNT_W     = 6,
  localparam int unsigned DEC_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_vld_i,
  input  logic [OPT_W-1:0]     req_opt_i,
  output logic                 req_rdy_o,
  input  logic [NUM_PORTS-1:0] rsp_vld_i,
  output logic [CNT_W-1:0]     cnt_o,
  input  logic                 err_clr_i,
  input  logic                 irq_en_i,
  output logic                 err_o,
  output logic                 irq_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sat, reach, inc;
  logic [DEC_W-1:0] ndec;
  cpl_opt_t         opt;

  assign opt       = cpl_opt_t'(req_opt_i);
  assign req_rdy_o = ~sat;
  assign inc       = req_vld_i & req_rdy_o & wants_report(opt);

  cpl_rsp_count #(.NUM_PORTS(NUM_PORTS)) u_rsp_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (rsp_vld_i),
    .num_o  (ndec)
  );

  cpl_cnt_core #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_cnt_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .ndec_i  (ndec),
    .cnt_o   (cnt_o),
    .sat_o   (sat),
    .reach_o (reach)
  );

  cpl_err_ctl u_err_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (reach),
    .clr_i    (err_clr_i),
    .irq_en_i (irq_en_i),
    .err_o    (err_o),
    .irq_o    (irq_o)
  );

  assert_reach_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnt_o == CNT_MAX) |-> err_o);

  assert_blocked_no_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && rsp_vld_i == '0 && req_vld_i) |=> (cnt_o == CNT_MAX));

  assert_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && rsp_vld_i != '0) |=> req_rdy_o);

endmodule

// File: tb/cpl_track_test.sv
`timescale 1ns/1ps
module cpl_track_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_vld_i = 1'b0;
  logic [3:0] req_opt_i = '0;
  logic       req_rdy_o;
  logic [5:0] rsp_vld_i = '0;
  logic [5:0] cnt_o;
  logic       err_clr_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       err_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cpl_track uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_vld_i(req_vld_i), .req_opt_i(req_opt_i),
    .req_rdy_o(req_rdy_o), .rsp_vld_i(rsp_vld_i), .cnt_o(cnt_o),
    .err_clr_i(err_clr_i), .irq_en_i(irq_en_i), .err_o(err_o), .irq_o(irq_o)
  );

  // {req_vld, opt[3:0], rsp[5:0], expected count}
  localparam logic [16:0] VEC [12] = '{
    {1'b1, 4'b0001, 6'b000000, 6'd1},  // R2 final irq
    {1'b1, 4'b0010, 6'b000000, 6'd2},  // R2 final chain
    {1'b1, 4'b0100, 6'b000000, 6'd3},  // R2 intermediate irq
    {1'b1, 4'b1000, 6'b000000, 6'd4},  // R2 intermediate chain
    {1'b1, 4'b0000, 6'b000000, 6'd4},  // R2 no report requested
    {1'b0, 4'b0000, 6'b000011, 6'd2},  // R3 two ports
    {1'b1, 4'b0001, 6'b000001, 6'd2},  // R4 cancel
    {1'b1, 4'b1111, 6'b000000, 6'd3},  // R2 all options
    {1'b1, 4'b0001, 6'b010101, 6'd1},  // R4 +1 -3
    {1'b0, 4'b0000, 6'b111111, 6'd0},  // R5 clamp
    {1'b0, 4'b0000, 6'b100000, 6'd0},  // R5 uncounted at zero
    {1'b0, 4'b1111, 6'b000000, 6'd0}   // R2 not valid
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [3:0] o, logic [5:0] r, logic c);
    req_vld_i = v; req_opt_i = o; rsp_vld_i = r; err_clr_i = c;
    @(posedge clk);
    @(negedge clk);
    req_vld_i = 1'b0; req_opt_i = '0; rsp_vld_i = '0; err_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 count", int'(cnt_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 rdy", int'(req_rdy_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][16], VEC[i][15:12], VEC[i][11:6], 1'b0);
      check($sformatf("R11 vector %0d", i), int'(cnt_o), int'(VEC[i][5:0]));
    end

    for (int i = 0; i < 62; i++) step(1'b1, 4'b0001, 6'b0, 1'b0);
    check("R2 fill to 62", int'(cnt_o), 62);
    check("R8 no error below max", int'(err_o), 0);
    step(1'b1, 4'b0001, 6'b0, 1'b0);
    check("R6 count at max", int'(cnt_o), 63);
    check("R6 rdy low", int'(req_rdy_o), 0);
    check("R8 error set", int'(err_o), 1);
    check("R10 irq masked", int'(irq_o), 0);
    irq_en_i = 1'b1;
    #1;
    check("R10 irq enabled", int'(irq_o), 1);

    step(1'b1, 4'b1111, 6'b0, 1'b0);
    check("R6 blocked request", int'(cnt_o), 63);
    step(1'b1, 4'b0001, 6'b111111, 1'b0);
    check("R3 six ports while blocked", int'(cnt_o), 57);
    check("R7 rdy back", int'(req_rdy_o), 1);
    check("R8 sticky", int'(err_o), 1);
    step(1'b1, 4'b0001, 6'b0, 1'b0);
    check("R7 counted again", int'(cnt_o), 58);

    step(1'b0, 4'b0, 6'b0, 1'b1);
    check("R9 cleared", int'(err_o), 0);
    check("R10 irq follows", int'(irq_o), 0);
    check("R9 count untouched", int'(cnt_o), 58);

    for (int i = 0; i < 4; i++) step(1'b1, 4'b0100, 6'b0, 1'b0);
    check("R9 pre-max", int'(err_o), 0);
    step(1'b1, 4'b0100, 6'b0, 1'b1);
    check("R9 set wins count", int'(cnt_o), 63);
    check("R9 set wins err", int'(err_o), 1);
    step(1'b0, 4'b0, 6'b0, 1'b1);
    check("R9 clear at max", int'(err_o), 0);
    check("R6 still max", int'(cnt_o), 63);

    rst_ni = 1'b0;
    #1;
    check("R1 async count", int'(cnt_o), 0);
    check("R1 async err", int'(err_o), 0);
    check("R1 async irq", int'(irq_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule